// File: doc/BRIEF.md
# Renaming Reorder Buffer Core

This block is a small out-of-order execution core. Instructions enter one per cycle, in program order. Each one names a destination register, two source registers and an operation. The core places each instruction in a circular reorder buffer. It also points the destination register's rename entry at that buffer slot, so later readers of the register wait for that slot and not for older writers.

Each source is resolved when the instruction is dispatched. It takes its value from one of three places: the same-cycle result broadcast, a buffer slot that has already finished, or the architectural value. If none of these applies, the source keeps the tag of the slot it waits on. A single ALU starts the oldest instruction whose two operands are both present. It broadcasts the result one cycle later on the result bus, and waiting operands with a matching tag capture it there. Finished slots leave the buffer from the head in program order through the retire port, which updates the architectural register file.

Top module: `ooo_core`

## Requirements
- R1: Out of reset, `disp_ready` is 1, while `ret_valid` and `bus_valid` are 0.
- R2: Buffer tags are handed out in dispatch order, wrapping modulo DEPTH and starting at 0 after reset. Each dispatched instruction is broadcast on the bus under its own tag.
- R3: Once DEPTH instructions are in flight, `disp_ready` is 0. An offered instruction is then ignored: it occupies no slot and never retires.
- R4: Whenever a register is marked as renamed, its tag names an occupied slot whose destination is that register.
- R5: Every occupied slot has its destination register marked as renamed. The tag in that rename entry names this slot or a younger one.
- R6: Each dispatched instruction appears on the result bus exactly once, carrying its computed value. A source waiting on that tag captures the value.
- R7: A source is resolved at dispatch in this order: a matching same-cycle broadcast, then a finished slot named by the rename tag, then the architectural value when the register is not renamed. All three paths yield the value that in-order execution would give.
- R8: Retirement is in program order from the head. `ret_dst` and `ret_value` show the instruction's destination and result, which are written to the architectural file. A rename entry is cleared only if its tag still names the retiring slot. An architectural read in the same cycle as a retire write to that register returns the new value.
- R9: Opcode encoding of `disp_op`: 0 adds, 1 subtracts (first source minus second), 2 is bitwise AND and 3 is bitwise XOR. All results wrap to DW bits.
- R10: After reset, architectural register r holds the value r.
- R11: At most one instruction issues per cycle, always the oldest ready one. An instruction that is ready when it enters issues in the next cycle, and its result is on the bus in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Instruction offered for dispatch |
| disp_op | input | 2 | Operation code (R9) |
| disp_dst | input | log2(NREG) | Destination register |
| disp_src1 | input | log2(NREG) | First source register |
| disp_src2 | input | log2(NREG) | Second source register |
| disp_ready | output | 1 | Buffer has a free slot; dispatch happens when both are 1 |
| bus_valid | output | 1 | Result broadcast this cycle |
| bus_tag | output | log2(DEPTH) | Buffer slot of the broadcast result |
| bus_value | output | DW | Broadcast result value |
| ret_valid | output | 1 | Head instruction retires at the next edge |
| ret_dst | output | log2(NREG) | Destination of the retiring instruction |
| ret_value | output | DW | Value written to the architectural register |

## Verification
The hardest case to reach from the ports is a consumer that dispatches in exactly the cycle its producer's result is on the bus. At that moment the rename tag is live but the slot is not yet marked finished, so only the forwarding path can supply the value. The stimulus sends a producer and then a consumer after gaps of zero to three cycles, which walks the consumer's dispatch across the broadcast cycle. Back-to-back dependent chains fill the buffer so that stalls and rename entries that outlive their retiring writer also occur. A program-order model predicts every bus value and retire value.

// File: rtl/ooo_pkg.sv
package ooo_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_AND = 2'd2,
    OP_XOR = 2'd3
  } op_e;
endpackage

// File: rtl/ooo_rename.sv
module ooo_rename #(
  parameter int NREG  = 8,
  parameter int DEPTH = 4,
  parameter int DW    = 16
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    disp_fire,
  input  logic [$clog2(NREG)-1:0]                 disp_dst,
  input  logic [$clog2(DEPTH)-1:0]                alloc_tag,
  input  logic [1:0][$clog2(NREG)-1:0]            rd_addr,
  input  logic                                    ret_fire,
  input  logic [$clog2(DEPTH)-1:0]                ret_tag,
  input  logic [$clog2(NREG)-1:0]                 ret_dst,
  input  logic [DW-1:0]                           ret_value,
  output logic [1:0]                              src_renamed,
  output logic [1:0][$clog2(DEPTH)-1:0]           src_tag,
  output logic [1:0][DW-1:0]                      src_arch,
  output logic [NREG-1:0]                         map_valid,
  output logic [NREG-1:0][$clog2(DEPTH)-1:0]      map_tag
);
  localparam int RW = $clog2(NREG);

  logic [DW-1:0] arch_q [NREG];

  // architectural read with write-before-read bypass (R8)
  function automatic logic [DW-1:0] arch_read(input logic [RW-1:0] a);
    if (ret_fire && ret_dst == a) return ret_value;
    return arch_q[a];
  endfunction

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      src_renamed[s] = map_valid[rd_addr[s]];
      src_tag[s]     = map_tag[rd_addr[s]];
      src_arch[s]    = arch_read(rd_addr[s]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) begin
        arch_q[r]  <= DW'(r);
        map_valid[r] <= 1'b0;
        map_tag[r] <= '0;
      end
    end else begin
      if (ret_fire) begin
        arch_q[ret_dst] <= ret_value;
        if (map_valid[ret_dst] && map_tag[ret_dst] == ret_tag)
          map_valid[ret_dst] <= 1'b0;
      end
      if (disp_fire) begin
        map_valid[disp_dst] <= 1'b1;
        map_tag[disp_dst]   <= alloc_tag;
      end
    end
  end
endmodule

// File: rtl/ooo_rob.sv
module ooo_rob
  import ooo_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int NREG  = 8,
  parameter int DW    = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               disp_valid,
  input  op_e                                disp_op,
  input  logic [$clog2(NREG)-1:0]            disp_dst,
  input  logic [1:0]                         src_renamed,
  input  logic [1:0][$clog2(DEPTH)-1:0]      src_tag,
  input  logic [1:0][DW-1:0]                 src_arch,
  input  logic                               bus_valid,
  input  logic [$clog2(DEPTH)-1:0]           bus_tag,
  input  logic [DW-1:0]                      bus_value,
  output logic                               disp_ready,
  output logic                               disp_fire,
  output logic [$clog2(DEPTH)-1:0]           alloc_tag,
  output logic                               issue_valid,
  output logic [$clog2(DEPTH)-1:0]           issue_tag,
  output op_e                                issue_op,
  output logic [DW-1:0]                      issue_a,
  output logic [DW-1:0]                      issue_b,
  output logic                               ret_fire,
  output logic [$clog2(DEPTH)-1:0]           ret_tag,
  output logic [$clog2(NREG)-1:0]            ret_dst,
  output logic [DW-1:0]                      ret_value,
  output logic [DEPTH-1:0]                   ent_valid,
  output logic [DEPTH-1:0][$clog2(NREG)-1:0] ent_dst
);
  localparam int TW = $clog2(DEPTH);
  localparam int RW = $clog2(NREG);
  localparam logic [TW:0] FULL_COUNT = (TW+1)'(DEPTH);

  logic [TW:0]     head_q, tail_q, count;
  logic [DEPTH-1:0] e_done, e_issued;
  logic [DW-1:0]   e_value [DEPTH];
  op_e             e_op    [DEPTH];
  logic [1:0]      e_sv    [DEPTH];
  logic [DW-1:0]   e_sval  [DEPTH][2];
  logic [TW-1:0]   e_stag  [DEPTH][2];
  logic [1:0]          rs_valid;
  logic [1:0][DW-1:0]  rs_value;

  assign count      = tail_q - head_q;
  assign disp_ready = (count != FULL_COUNT);
  assign disp_fire  = disp_valid && disp_ready;
  assign alloc_tag  = tail_q[TW-1:0];
  assign ret_tag    = head_q[TW-1:0];
  assign ret_fire   = ent_valid[ret_tag] && e_done[ret_tag];
  assign ret_dst    = ent_dst[ret_tag];
  assign ret_value  = e_value[ret_tag];

  // source resolution at dispatch (R7)
  always_comb begin
    for (int s = 0; s < 2; s++) begin
      if (src_renamed[s] && bus_valid && bus_tag == src_tag[s]) begin
        rs_valid[s] = 1'b1; rs_value[s] = bus_value;
      end else if (src_renamed[s] && e_done[src_tag[s]]) begin
        rs_valid[s] = 1'b1; rs_value[s] = e_value[src_tag[s]];
      end else if (!src_renamed[s]) begin
        rs_valid[s] = 1'b1; rs_value[s] = src_arch[s];
      end else begin
        rs_valid[s] = 1'b0; rs_value[s] = '0;
      end
    end
  end

  // oldest-ready selection, scanning from the head (R11)
  always_comb begin
    issue_valid = 1'b0;
    issue_tag   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [TW-1:0] idx;
      idx = head_q[TW-1:0] + TW'(k);
      if (!issue_valid && ent_valid[idx] && !e_issued[idx] && (&e_sv[idx])) begin
        issue_valid = 1'b1;
        issue_tag   = idx;
      end
    end
  end
  assign issue_op = e_op[issue_tag];
  assign issue_a  = e_sval[issue_tag][0];
  assign issue_b  = e_sval[issue_tag][1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        ent_valid[i] <= 1'b0; e_done[i] <= 1'b0; e_issued[i] <= 1'b0;
        ent_dst[i] <= '0; e_value[i] <= '0; e_op[i] <= OP_ADD; e_sv[i] <= '0;
        for (int s = 0; s < 2; s++) begin
          e_sval[i][s] <= '0; e_stag[i][s] <= '0;
        end
      end
    end else begin
      if (bus_valid) begin
        for (int i = 0; i < DEPTH; i++)
          for (int s = 0; s < 2; s++)
            if (ent_valid[i] && !e_sv[i][s] && e_stag[i][s] == bus_tag) begin
              e_sv[i][s]   <= 1'b1;
              e_sval[i][s] <= bus_value;
            end
        e_done[bus_tag]  <= 1'b1;
        e_value[bus_tag] <= bus_value;
      end
      if (issue_valid) e_issued[issue_tag] <= 1'b1;
      if (ret_fire) begin
        ent_valid[ret_tag] <= 1'b0;
        head_q <= head_q + 1'b1;
      end
      if (disp_fire) begin
        ent_valid[alloc_tag] <= 1'b1;
        e_done[alloc_tag]    <= 1'b0;
        e_issued[alloc_tag]  <= 1'b0;
        ent_dst[alloc_tag]   <= disp_dst;
        e_op[alloc_tag]      <= disp_op;
        e_sv[alloc_tag]      <= rs_valid;
        for (int s = 0; s < 2; s++) begin
          e_sval[alloc_tag][s] <= rs_value[s];
          e_stag[alloc_tag][s] <= src_tag[s];
        end
        tail_q <= tail_q + 1'b1;
      end
    end
  end

  assert_occupancy_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_COUNT);
  assert_stall_no_alloc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready) |=> tail_q == $past(tail_q));
  assert_broadcast_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (ent_valid[bus_tag] && e_issued[bus_tag] && !e_done[bus_tag]));
endmodule

// File: rtl/ooo_alu.sv
module ooo_alu
  import ooo_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int DW    = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     issue_valid,
  input  logic [$clog2(DEPTH)-1:0] issue_tag,
  input  op_e                      issue_op,
  input  logic [DW-1:0]            issue_a,
  input  logic [DW-1:0]            issue_b,
  output logic                     res_valid,
  output logic [$clog2(DEPTH)-1:0] res_tag,
  output logic [DW-1:0]            res_value
);
  // operation semantics (R9)
  function automatic logic [DW-1:0] alu_eval(input op_e op, input logic [DW-1:0] a,
                                             input logic [DW-1:0] b);
    case (op)
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_AND:  return a & b;
      default: return a ^ b;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_tag   <= '0;
      res_value <= '0;
    end else begin
      res_valid <= issue_valid;
      if (issue_valid) begin
        res_tag   <= issue_tag;
        res_value <= alu_eval(issue_op, issue_a, issue_b);
      end
    end
  end
endmodule

// File: rtl/ooo_core.sv
module ooo_core
  import ooo_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int DEPTH = 4,
  parameter int DW    = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     disp_valid,
  input  logic [1:0]               disp_op,
  input  logic [$clog2(NREG)-1:0]  disp_dst,
  input  logic [$clog2(NREG)-1:0]  disp_src1,
  input  logic [$clog2(NREG)-1:0]  disp_src2,
  output logic                     disp_ready,
  output logic                     bus_valid,
  output logic [$clog2(DEPTH)-1:0] bus_tag,
  output logic [DW-1:0]            bus_value,
  output logic                     ret_valid,
  output logic [$clog2(NREG)-1:0]  ret_dst,
  output logic [DW-1:0]            ret_value
);
  localparam int TW = $clog2(DEPTH);
  localparam int RW = $clog2(NREG);

  logic                          disp_fire, issue_valid;
  logic [TW-1:0]                 alloc_tag, issue_tag, ret_tag;
  op_e                           issue_op;
  logic [DW-1:0]                 issue_a, issue_b;
  logic [1:0]                    src_renamed;
  logic [1:0][TW-1:0]            src_tag;
  logic [1:0][DW-1:0]            src_arch;
  logic [NREG-1:0]               map_valid;
  logic [NREG-1:0][TW-1:0]       map_tag;
  logic [DEPTH-1:0]              ent_valid;
  logic [DEPTH-1:0][RW-1:0]      ent_dst;

  ooo_rename #(.NREG(NREG), .DEPTH(DEPTH), .DW(DW)) u_rename (
    .clk(clk), .rst_n(rst_n), .disp_fire(disp_fire), .disp_dst(disp_dst),
    .alloc_tag(alloc_tag), .rd_addr({disp_src2, disp_src1}),
    .ret_fire(ret_valid), .ret_tag(ret_tag), .ret_dst(ret_dst), .ret_value(ret_value),
    .src_renamed(src_renamed), .src_tag(src_tag), .src_arch(src_arch),
    .map_valid(map_valid), .map_tag(map_tag));

  ooo_rob #(.DEPTH(DEPTH), .NREG(NREG), .DW(DW)) u_rob (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_op(op_e'(disp_op)),
    .disp_dst(disp_dst), .src_renamed(src_renamed), .src_tag(src_tag),
    .src_arch(src_arch), .bus_valid(bus_valid), .bus_tag(bus_tag),
    .bus_value(bus_value), .disp_ready(disp_ready), .disp_fire(disp_fire),
    .alloc_tag(alloc_tag), .issue_valid(issue_valid), .issue_tag(issue_tag),
    .issue_op(issue_op), .issue_a(issue_a), .issue_b(issue_b),
    .ret_fire(ret_valid), .ret_tag(ret_tag), .ret_dst(ret_dst),
    .ret_value(ret_value), .ent_valid(ent_valid), .ent_dst(ent_dst));

  ooo_alu #(.DEPTH(DEPTH), .DW(DW)) u_alu (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_tag(issue_tag),
    .issue_op(issue_op), .issue_a(issue_a), .issue_b(issue_b),
    .res_valid(bus_valid), .res_tag(bus_tag), .res_value(bus_value));

  // age of a slot relative to the head, modulo DEPTH
  function automatic logic [TW-1:0] slot_age(input logic [TW-1:0] t);
    return t - ret_tag;
  endfunction

  for (genvar r = 0; r < NREG; r++) begin : g_map_chk
    assert_rename_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
      map_valid[r] |-> (ent_valid[map_tag[r]] && ent_dst[map_tag[r]] == RW'(r)));
  end
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent_chk
    assert_live_renamed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ent_valid[i] |-> (map_valid[ent_dst[i]] &&
                        slot_age(map_tag[ent_dst[i]]) >= slot_age(TW'(i))));
  end
endmodule

// File: tb/ooo_core_test.sv
module ooo_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 8, DEPTH = 4, DW = 16;
  localparam int RW = $clog2(NREG), TW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic disp_valid = 1'b0;
  logic [1:0] disp_op = '0;
  logic [RW-1:0] disp_dst = '0, disp_src1 = '0, disp_src2 = '0;
  logic disp_ready, bus_valid, ret_valid;
  logic [TW-1:0] bus_tag;
  logic [DW-1:0] bus_value, ret_value;
  logic [RW-1:0] ret_dst;

  ooo_core #(.NREG(NREG), .DEPTH(DEPTH), .DW(DW)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [RW-1:0] dst;
    logic [DW-1:0] val;
    string         req;
  } item_t;

  int checks = 0, fails = 0, stalls = 0, next_tag = 0;
  bit done = 0;
  logic [DW-1:0] gold [NREG];
  logic [DW-1:0] tag_exp [DEPTH];
  logic [DEPTH-1:0] tag_live = '0;
  item_t exp_q[$];
  int res_log[$];

  function automatic logic [DW-1:0] model(int op, logic [DW-1:0] a, logic [DW-1:0] b);
    if (op == 0) return DW'(a + b);
    if (op == 1) return DW'(a - b);
    if (op == 2) return a & b;
    return a ^ b;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver: offers one instruction, holds it through stalls, predicts its result
  task automatic send(int op, int d, int a, int b, string req);
    item_t it;
    @(negedge clk);
    disp_valid = 1'b1; disp_op = 2'(op);
    disp_dst = RW'(d); disp_src1 = RW'(a); disp_src2 = RW'(b);
    while (!disp_ready) begin
      stalls++;
      @(negedge clk);
    end
    @(posedge clk);
    #1;
    disp_valid = 1'b0;
    it.val = model(op, gold[a], gold[b]);
    it.dst = RW'(d);
    it.req = req;
    gold[d] = it.val;
    exp_q.push_back(it);
    tag_exp[next_tag] = it.val;
    tag_live[next_tag] = 1'b1;
    next_tag = (next_tag + 1) % DEPTH;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor: result bus and retire port against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (bus_valid) begin
        res_log.push_back(int'(bus_tag));
        check(tag_live[bus_tag], "R6", "broadcast of a live tag", bus_tag, bus_tag);
        check(bus_value == tag_exp[bus_tag], "R6", "bus value", bus_value, tag_exp[bus_tag]);
        tag_live[bus_tag] = 1'b0;
      end
      if (ret_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3", "retire with nothing expected", ret_dst, -1);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          check(ret_dst == it.dst, it.req, "retire destination (R8)", ret_dst, it.dst);
          check(ret_value == it.val, it.req, "retire value (R8)", ret_value, it.val);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int g;
    for (int r = 0; r < NREG; r++) gold[r] = DW'(r);   // R10 reset contents
    repeat (3) @(negedge clk);
    check(disp_ready == 1'b1, "R1", "ready during reset", disp_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(disp_ready == 1'b1, "R1", "ready after reset", disp_ready, 1);
    check(ret_valid == 1'b0, "R1", "no retire after reset", ret_valid, 0);
    check(bus_valid == 1'b0, "R1", "no result after reset", bus_valid, 0);

    // R9 R10: every opcode on reset register values, independent burst
    send(0, 1, 3, 5, "R10");
    send(1, 2, 3, 5, "R9");
    send(2, 4, 6, 7, "R9");
    send(3, 0, 6, 7, "R9");
    drain();
    check(gold[2] == 16'hFFFE, "R9", "model subtract wraps", gold[2], 16'hFFFE);
    // R2 R11: tags in dispatch order, broadcast oldest first
    check(res_log.size() == 4, "R2", "broadcast count", res_log.size(), 4);
    for (int i = 0; i < 4 && i < res_log.size(); i++)
      check(res_log[i] == i, "R2", "tag order on bus (R11)", res_log[i], i);

    // R11: result two negedges after dispatch edge
    res_log.delete();
    send(0, 5, 1, 2, "R11");
    @(negedge clk);
    check(bus_valid == 1'b0, "R11", "no result one cycle after dispatch", bus_valid, 0);
    @(negedge clk);
    check(bus_valid == 1'b1, "R11", "result two cycles after dispatch", bus_valid, 1);
    check(int'(bus_tag) == 0, "R11", "tag wraps to slot 0 (R2)", bus_tag, 0);
    drain();

    // R3 R7: dependent chain fills the buffer
    stalls = 0;
    for (int i = 0; i < 10; i++) send(0, 1, 1, 3, "R7");
    check(stalls > 0, "R3", "dispatch stalled when full", stalls, 1);
    drain();

    // R7: consumer dispatched 0..3 cycles after producer (bus-forward path)
    for (int gap = 0; gap < 4; gap++) begin
      send(1, 5, 2, 3, "R7");
      repeat (gap) @(negedge clk);
      send(3, 6, 5, 1, "R7");
      send(0, 7, 6, 5, "R7");
      drain();
    end

    // R8: register rewritten while older writer retires; rename must survive
    send(0, 2, 1, 1, "R8");
    send(0, 3, 2, 2, "R8");
    send(0, 2, 3, 3, "R8");
    send(0, 2, 2, 3, "R8");
    repeat (3) @(negedge clk);
    send(2, 4, 2, 2, "R8");
    drain();
    send(3, 4, 2, 4, "R8");
    drain();

    // R6: random program with random gaps
    for (int i = 0; i < 300; i++) begin
      g = $urandom_range(0, 3);
      if (g == 3) repeat ($urandom_range(1, 3)) @(negedge clk);
      send($urandom_range(0, 3), $urandom_range(0, NREG-1),
           $urandom_range(0, NREG-1), $urandom_range(0, NREG-1), "R6");
    end
    drain();
    check(exp_q.size() == 0, "R8", "all instructions retired", exp_q.size(), 0);
    check(tag_live == '0, "R6", "every tag broadcast", tag_live, 0);
    check(ret_valid == 1'b0 && disp_ready == 1'b1, "R3", "idle after drain", ret_valid, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule